// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A behavioural, synthesizable model of a single-ported synchronous SRAM. All of its control, address and data inputs are registered on the rising clock edge, and its read path goes through an output register. The data path is 32 bits wide and is split into four byte lanes. The address width is a parameter and defaults to a small array. In place of a tristate pin, the model has a separate write-data input, a read-data output and a bus-drive enable.

An access starts on one of two address strobes. The processor strobe always starts a read. The controller strobe can start a read or a write that finishes in one clock. Three chip enables decide whether a strobed cycle selects the device or deselects it. On cycles with no strobe, the device works at the address it already holds: it reads, or it writes whatever the write controls call for. A global write enable forces all four bytes to be written. Otherwise a byte write enable and four byte selects choose which lanes are written.

The output enable acts asynchronously, but it only opens the bus when the device is in an established read stream. The bus stays released on write cycles, on deselect cycles and on the first read after the device is selected. Burst address generation and sleep control belong to neighbouring blocks. On cycles with no strobe, the address in use is simply the one captured last.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and on the cycle after it is released, `dout_en` is 0 and `dout` is all zeros.
- R2: A read decoded at clock edge k loads the stored word at the read address into `dout` at edge k+1. The word read is the one present before any write made at edge k+1.
- R3: `dout_en` is 1 only when all three of these hold: `oe_n` is 0, the cycle decoded at the last edge is a read, and the cycle decoded at the edge before that is also a read.
- R4: When a read selects the device and the cycle before it was a deselect or idle cycle, `dout_en` is 0 after that edge, whatever `oe_n` holds.
- R5: After an edge that decodes a write cycle or a deselect cycle, `dout_en` is 0 regardless of `oe_n`.
- R6: When `adsp_n` and `adsc_n` are both 0 and `ce1_n` is 0, the cycle is handled as a processor-strobe cycle. It is a read if the enables select the device, and it never writes.
- R7: When `ce1_n` is 1, `adsp_n` has no effect. On such a cycle with `adsc_n` at 1, a selected device treats the cycle as a continue cycle on its held address.
- R8: The chip enables (`ce1_n`, `ce2`, `ce3_n`) are looked at only on cycles that load an address. On cycles with no strobe they have no effect.
- R9: A cycle started by the processor strobe is a read, and the write controls are ignored on it. A write to that captured address can be made on the next clock, as a no-strobe cycle.
- R10: A cycle started by the controller strobe (with `adsp_n` at 1 or ignored), with the device selected and a write requested, writes `din` at the presented address at that same edge.
- R11: `gw_n` at 0 writes all four bytes. Otherwise byte lane i (bits 8i+7:8i) is written only when `bwe_n` is 0 and `bw_n[i]` is 0. Lanes that are not written keep their contents. A cycle is a write when at least one lane is to be written.
- R12: A strobed cycle whose chip enables are not all active is a deselect cycle. It writes nothing, leaves `dout` unchanged and puts the device in the deselected state. Cycles with no strobe then do nothing until the next selecting strobe.
- R13: `oe_n` acts combinationally: within a cycle, raising it drops `dout_en` at once, and lowering it raises `dout_en` at once if R3 otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address, captured on strobe cycles |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*8 | Write data |
| dout | output | LANES*8 | Registered read data |
| dout_en | output | 1 | Bus-drive enable for dout |

## Verification
On every cycle, assertions check the following:
- the bus stays released after write and deselect edges and after a read that first selects the device;
- the processor strobe never turns into a write;
- a deselect writes no lane;
- the read register holds on cycles that do not read.

Only the bench's scenarios can show the rest:
- that data actually lands in the right lanes and comes back with the stated latency;
- that the chip enables are really ignored on continue cycles;
- that an ignored processor strobe falls through to a continue write;
- that the output enable takes effect in the middle of a cycle.

// File: rtl/burst_sram_pkg.sv
// Package: shared types for the burst SRAM model.
// Assumes byte-wide lanes; the lane count is set at the top level.
package burst_sram_pkg;
    localparam int LANE_W = 8;

    // Kind of cycle decoded at a clock edge.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,   // deselected, no strobe: nothing happens
        CYC_DESEL = 2'd1,   // strobe with an inactive chip enable
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_e;
endpackage

// File: rtl/burst_sram_decode.sv
// Module: cycle decoder.
// Purely combinational classification of the inputs sampled at the coming edge:
// strobe priority, chip-enable qualification and the per-lane write mask.
// Assumes sel_q is the registered "device selected" state.
module burst_sram_decode
    import burst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             sel_q,
    output cyc_e             cyc,
    output logic             load_addr,
    output logic [LANES-1:0] lane_we
);
    logic             proc_go;
    logic             strobe;
    logic             enabled;
    logic [LANES-1:0] req_mask;

    // Strobe qualification: the processor strobe needs ce1 and wins over the controller.
    always_comb begin
        proc_go = !adsp_n && !ce1_n;
        strobe  = proc_go || !adsc_n;
        enabled = !ce1_n && ce2 && !ce3_n;
    end

    // Requested lanes: global write overrides the byte-write path.
    always_comb begin
        if (!gw_n)       req_mask = '1;
        else if (!bwe_n) req_mask = ~bw_n;
        else             req_mask = '0;
    end

    // Cycle classification.
    always_comb begin
        load_addr = 1'b0;
        if (strobe) begin
            if (!enabled)            cyc = CYC_DESEL;
            else if (proc_go)        cyc = CYC_READ;
            else if (|req_mask)      cyc = CYC_WRITE;
            else                     cyc = CYC_READ;
            load_addr = enabled;
        end else if (sel_q) begin
            cyc = (|req_mask) ? CYC_WRITE : CYC_READ;
        end else begin
            cyc = CYC_IDLE;
        end
    end

    // Lane write enables are only live on write cycles.
    always_comb lane_we = (cyc == CYC_WRITE) ? req_mask : '0;
endmodule

// File: rtl/burst_sram_lane.sv
// Module: one byte lane of storage with its output register.
// Writes at the edge when we is high. When rd_en is high, q loads the word that
// was stored before this edge's write. Storage is not reset; q is.
module burst_sram_lane #(
    parameter int ADDR_W = 6,
    parameter int W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Pipelined read register.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (rd_en) q <= mem[raddr];
    end

    // R12: output register is untouched on cycles that do not read.
    assert_q_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(q));
endmodule

// File: rtl/burst_sram_bus.sv
// Module: selection state and bus-drive control.
// Tracks whether the device is selected and which of the last two edges decoded reads.
// The drive enable needs an established read stream and an active oe_n.
module burst_sram_bus
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cyc_e cyc,
    input  logic oe_n,
    output logic sel_q,
    output logic rd_en,
    output logic dout_en
);
    logic cur_read_q;
    logic prev_read_q;

    // Selection flag: set by a selecting strobe, cleared by a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sel_q <= 1'b0;
        else if (cyc == CYC_DESEL)   sel_q <= 1'b0;
        else if (cyc != CYC_IDLE)    sel_q <= 1'b1;
    end

    // Read history over the last two edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_read_q  <= 1'b0;
            prev_read_q <= 1'b0;
        end else begin
            cur_read_q  <= (cyc == CYC_READ);
            prev_read_q <= cur_read_q;
        end
    end

    assign rd_en   = cur_read_q;
    assign dout_en = !oe_n && cur_read_q && prev_read_q;

    // R5: a write edge releases the bus.
    assert_wr_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE) |=> !dout_en);
    // R5: a deselect edge releases the bus.
    assert_desel_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> !dout_en);
    // R4: first read after being deselected is never driven.
    assert_first_read_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && cyc == CYC_READ) |=> !dout_en);
endmodule

// File: rtl/burst_sram.sv
// Module: pipelined synchronous burst SRAM, top level.
// Registers the address on selecting strobes and splits storage into byte lanes.
// Presents read data, plus a drive enable in place of a tristate bus.
// Assumes burst address stepping is done outside: cycles with no strobe use the held address.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     adsp_n,
    input  logic                     adsc_n,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [LANES-1:0]         bw_n,
    input  logic                     oe_n,
    input  logic [LANES*LANE_W-1:0]  din,
    output logic [LANES*LANE_W-1:0]  dout,
    output logic                     dout_en
);
    localparam int DATA_W = LANES * LANE_W;

    cyc_e              cyc;
    logic              load_addr;
    logic [LANES-1:0]  lane_we;
    logic              sel_q;
    logic              rd_en;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] waddr;

    burst_sram_decode #(.LANES(LANES)) u_decode (
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .sel_q    (sel_q),
        .cyc      (cyc),
        .load_addr(load_addr),
        .lane_we  (lane_we)
    );

    burst_sram_bus u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc    (cyc),
        .oe_n   (oe_n),
        .sel_q  (sel_q),
        .rd_en  (rd_en),
        .dout_en(dout_en)
    );

    // Address register: loads only on a selecting strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (load_addr) addr_q <= addr;
    end

    // Write address: a strobed write uses the presented address in the same clock.
    assign waddr = load_addr ? addr : addr_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        burst_sram_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (lane_we[g]),
            .waddr(waddr),
            .wdata(din[g*LANE_W +: LANE_W]),
            .rd_en(rd_en),
            .raddr(addr_q),
            .q    (dout[g*LANE_W +: LANE_W])
        );
    end

    // R6 / R9: a qualified processor strobe never produces a write.
    assert_proc_never_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> (cyc != CYC_WRITE));
    // R12: a deselect cycle writes no lane.
    assert_desel_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |-> (lane_we == '0));

    logic unused_width;
    assign unused_width = ^DATA_W;
endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0;
    logic [31:0]   din = '0;
    logic [31:0]   dout;
    logic          dout_en;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(4)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // Behavioural reference state.
    logic [31:0] m_mem [DEPTH];
    logic [AW-1:0] m_addr;
    logic [31:0] m_dout;
    bit m_sel, m_cur_rd, m_prev_rd;

    int checks = 0, errors = 0;
    string tag = "R1";
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference update for one clock edge, using the inputs as sampled.
    task automatic model_step();
        bit proc, strobe, en, is_wr, is_rd;
        logic [3:0] mask;
        logic [AW-1:0] wa;
        proc   = !adsp_n && !ce1_n;
        strobe = proc || !adsc_n;
        en     = !ce1_n && ce2 && !ce3_n;
        mask   = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        is_wr = 0; is_rd = 0;
        if (strobe) begin
            if (en) begin
                if (proc || mask == 0) is_rd = 1; else is_wr = 1;
            end
        end else if (m_sel) begin
            if (mask == 0) is_rd = 1; else is_wr = 1;
        end
        if (m_cur_rd) m_dout = m_mem[m_addr];
        wa = (strobe && en) ? addr : m_addr;
        if (is_wr)
            for (int b = 0; b < 4; b++)
                if (mask[b]) m_mem[wa][b*8 +: 8] = din[b*8 +: 8];
        if (strobe) begin
            m_sel = en;
            if (en) m_addr = addr;
        end
        m_prev_rd = m_cur_rd;
        m_cur_rd  = is_rd;
    endtask

    task automatic compare();
        check(tag, {31'd0, dout_en}, {31'd0, (!oe_n && m_cur_rd && m_prev_rd)});
        check(tag, dout, m_dout);
    endtask

    // One clock: inputs already driven; update model at the edge, check at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic ctrl_write(input logic [AW-1:0] a, input logic [31:0] d);
        idle(); adsc_n = 0; addr = a; gw_n = 0; din = d; tick();
    endtask

    task automatic ctrl_read(input logic [AW-1:0] a);
        idle(); adsc_n = 0; addr = a; tick();
    endtask

    task automatic proc_read(input logic [AW-1:0] a);
        idle(); adsp_n = 0; addr = a; tick();
    endtask

    task automatic deselect();
        idle(); adsc_n = 0; ce2 = 0; tick();
    endtask

    initial begin
        m_sel = 0; m_cur_rd = 0; m_prev_rd = 0; m_addr = '0; m_dout = '0;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        tag = "R1";
        check("R1", {31'd0, dout_en}, 32'd0);
        check("R1", dout, 32'd0);
        rst_n = 1; idle(); adsc_n = 1; ce2 = 0;
        tick();
        check("R1", {31'd0, dout_en}, 32'd0);

        // R10 / R11: fill memory with controller-strobe global writes
        tag = "R10";
        for (int i = 0; i < DEPTH; i++) ctrl_write(i[AW-1:0], 32'hA500_0000 + i * 32'h0101_0203);

        // R2 / R3: back-to-back reads through both strobes and continue reads
        tag = "R2";
        deselect();
        proc_read(6'd3);
        ctrl_read(6'd4);
        proc_read(6'd5);
        idle(); tick(); tick();
        tag = "R3";
        oe_n = 1; proc_read(6'd9); idle(); tick(); oe_n = 0; tick();

        // R4: first read after a deselect is masked
        tag = "R4";
        deselect(); proc_read(6'd10); idle(); tick(); tick();

        // R9: processor-strobe cycle ignores write controls; write follows next clock
        tag = "R9";
        idle(); adsp_n = 0; addr = 6'd12; gw_n = 0; din = 32'hDEAD_BEEF; tick();
        idle(); gw_n = 0; din = 32'h1234_5678; tick();
        proc_read(6'd12); idle(); tick(); tick();

        // R11: byte-lane writes with assorted masks, then read back
        tag = "R11";
        idle(); adsc_n = 0; addr = 6'd20; bwe_n = 0; bw_n = 4'b1010; din = 32'h1122_3344; tick();
        idle(); bwe_n = 0; bw_n = 4'b0111; din = 32'h9900_0000; tick();
        idle(); bwe_n = 1; bw_n = 4'b0000; din = 32'hFFFF_FFFF; tick();
        idle(); gw_n = 0; bwe_n = 1; bw_n = 4'hF; adsc_n = 0; addr = 6'd21; din = 32'h0BAD_F00D; tick();
        proc_read(6'd20); proc_read(6'd21); idle(); tick();

        // R5: write cycles release the bus even with oe_n low
        tag = "R5";
        proc_read(6'd30); idle(); tick();
        idle(); bwe_n = 0; bw_n = 4'b1110; din = 32'h0000_00EE; tick();
        idle(); tick(); tick();

        // R6: both strobes with write controls: processor wins, cycle is a read
        tag = "R6";
        idle(); adsp_n = 0; adsc_n = 0; addr = 6'd33; gw_n = 0; din = 32'h6666_6666; tick();
        idle(); tick(); tick();

        // R7: processor strobe with ce1_n high is ignored -> continue write at held address
        tag = "R7";
        idle(); adsp_n = 0; ce1_n = 1; addr = 6'd40; gw_n = 0; din = 32'h7777_0001; tick();
        idle(); tick(); tick();
        proc_read(6'd40); idle(); tick(); tick();

        // R8: chip enables ignored on continue cycles
        tag = "R8";
        proc_read(6'd41);
        idle(); ce2 = 0; ce3_n = 1; tick();
        idle(); ce1_n = 1; gw_n = 0; din = 32'h8888_0008; tick();
        idle(); tick(); tick();

        // R12: deselect writes nothing, holds dout, later continue cycles idle
        tag = "R12";
        proc_read(6'd42); idle(); tick();
        idle(); adsc_n = 0; ce3_n = 1; addr = 6'd42; gw_n = 0; din = 32'hBADB_AD00; tick();
        idle(); gw_n = 0; din = 32'hBADB_AD11; tick();
        idle(); tick();
        proc_read(6'd42); idle(); tick(); tick();

        // R13: oe_n acts combinationally inside a cycle
        tag = "R13";
        proc_read(6'd50); idle(); tick();
        oe_n = 1; #0.5; compare();
        oe_n = 0; #0.5; compare();
        tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule